// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block sits beside a small 8-bit CPU core and decides when, and to which handler, control is diverted. It holds an 8-bit source-enable register and a five-bit request-flag register. Both are reachable over a byte-wide memory-mapped bus. It also holds a global interrupt-enable bit that the CPU sets and clears with single-cycle strobes. Peripherals raise requests by pulsing bits of `irq_req`. A request is pending when its enable bit and its flag bit are both set.

At each instruction boundary the CPU pulses `insn_boundary`. If the global enable is set and any request is pending, the block starts a dispatch in place of that instruction. It clears the global enable and clears the flag bit of the winning source only, lowest bit first. It then spends five machine cycles of four clocks each on the dispatch. During that time it writes the return address to the stack as two byte stores: high byte first at SP-1, then low byte at SP-2. It then presents the handler vector and the new stack pointer with a one-cycle `done` pulse.

Independently of the global enable, the block raises `halt_wake` while the CPU reports that it is halted and any request is pending.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: A dispatch starts on a clock edge where `insn_boundary`, the global enable and at least one pending source (enable bit and flag bit both 1) are all true and no dispatch is in progress; `busy` is high from the next cycle. Boundaries with the global enable clear, with nothing pending, or while `busy` is high start nothing.
- R2: With several sources pending, the source with the lowest bit index wins.
- R3: The handler vector for source i is 0x0040 + 8*i (0x0040, 0x0048, 0x0050, 0x0058, 0x0060) and is on `pc_out` in the cycle `done` is high.
- R4: The global enable (`ime`) is 0 after reset. It becomes 1 one edge after `ime_set` and 0 one edge after `ime_clr`; `ime_clr` wins over `ime_set`. It is forced to 0 on the edge that starts a dispatch.
- R5: The edge that starts a dispatch clears only the winning flag bit; all other flag bits keep their value.
- R6: A dispatch writes the captured `pc_in` to the stack in two single-cycle `stack_we` strobes. The first strobe comes in busy cycle 9 and writes the high byte to SP-1. The second comes in busy cycle 13 and writes the low byte to SP-2. SP is the captured `sp_in`. `sp_out` equals SP-2 when `done` is high.
- R7: `busy` stays high for exactly 20 cycles (5 machine cycles of 4 clocks). `done` is high only in the 20th of them.
- R8: `halt_wake` is 1 whenever `cpu_halted` is 1 and any source is pending, whatever the value of the global enable.
- R9: A read of address 0xFFFF returns the full 8-bit enable register. A read of 0xFF0F returns the flags in bits 4:0 with bits 7:5 reading as 1. Any other address reads 0x00. Enable bits 7:5 never make a source pending. After reset both registers hold 0.
- R10: A bus write to 0xFF0F replaces flag bits 4:0 and takes precedence over a dispatch clear on the same edge. An `irq_req` bit set on an edge is kept whatever else happens on that edge, including a dispatch clear of the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address for register reads and writes |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational from `bus_addr`) |
| irq_req | input | 5 | Per-source request set pulses from peripherals |
| ime_set | input | 1 | Strobe that sets the global enable |
| ime_clr | input | 1 | Strobe that clears the global enable |
| ime | output | 1 | Current global enable |
| cpu_halted | input | 1 | CPU is in its halted state |
| halt_wake | output | 1 | Halt exit request |
| insn_boundary | input | 1 | CPU is between instructions, before the next fetch |
| pc_in | input | 16 | Return address, captured when a dispatch starts |
| sp_in | input | 16 | Stack pointer, captured when a dispatch starts |
| busy | output | 1 | Dispatch in progress |
| stack_we | output | 1 | Stack byte write strobe |
| stack_addr | output | 16 | Stack write address |
| stack_wdata | output | 8 | Stack write data |
| pc_out | output | 16 | Handler vector |
| sp_out | output | 16 | Stack pointer after the push |
| done | output | 1 | Single-cycle dispatch completion; `pc_out` and `sp_out` are valid |

## Verification
Register results land one edge after the strobe that causes them. The enable and flag registers, the global enable and the rise of `busy` all follow the sampling edge. Read data and `halt_wake` follow their inputs within the same cycle. Within a dispatch, the stack strobes fall in the 9th and 13th busy cycles and `done` in the 20th. The bench changes inputs only on falling edges. It compares every output with a behavioural model 1 ns after each rising edge, so each registered result is checked in the first cycle it is due. Vector, stack and new-SP values are compared only in the cycles where they are defined to be valid.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam logic [15:0] ADDR_ENABLE = 16'hFFFF;
  localparam logic [15:0] ADDR_FLAGS  = 16'hFF0F;
  localparam logic [15:0] VEC_BASE    = 16'h0040;
  localparam int unsigned VEC_STRIDE  = 8;

  // Handler address for a source index.
  function automatic logic [15:0] vector_for(input int unsigned idx);
    return VEC_BASE + 16'(idx * VEC_STRIDE);
  endfunction

  // Stack slot a given number of bytes below the captured pointer.
  function automatic logic [15:0] stack_slot(input logic [15:0] sp, input int unsigned depth);
    return sp - 16'(depth);
  endfunction
endpackage

// File: rtl/irqd_regs.sv
module irqd_regs #(
  parameter int unsigned N_SRC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] ack,
  input  logic             take,
  input  logic             ime_set,
  input  logic             ime_clr,
  output logic [7:0]       en_q,
  output logic [N_SRC-1:0] flag_q,
  output logic             flag_wr,
  output logic             ime_q,
  output logic [7:0]       rdata
);
  import irqd_pkg::*;

  localparam logic [7:0] FLAG_MASK = 8'((1 << N_SRC) - 1);

  logic             en_wr;
  logic [N_SRC-1:0] flag_d;
  logic             ime_d;

  assign en_wr   = bus_wr && (bus_addr == ADDR_ENABLE);
  assign flag_wr = bus_wr && (bus_addr == ADDR_FLAGS);

  // Bus write beats the dispatch clear; peripheral sets beat both.
  always_comb begin
    if (flag_wr) flag_d = bus_wdata[N_SRC-1:0];
    else         flag_d = flag_q & ~ack;
    flag_d = flag_d | irq_req;
  end

  always_comb begin
    if (take || ime_clr) ime_d = 1'b0;
    else if (ime_set)    ime_d = 1'b1;
    else                 ime_d = ime_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
      ime_q  <= 1'b0;
    end else begin
      if (en_wr) en_q <= bus_wdata;
      flag_q <= flag_d;
      ime_q  <= ime_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_ENABLE: rdata = en_q;
      ADDR_FLAGS:  rdata = ~FLAG_MASK | 8'(flag_q);
      default:     rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
  parameter int unsigned N_SRC = 5,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // higher[i]: some source with a smaller index is pending.
  logic [N_SRC:0] higher;
  assign higher[0] = 1'b0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_chain
    assign grant[i]    = pend[i] & ~higher[i];
    assign higher[i+1] = higher[i] | pend[i];
  end

  assign any = higher[N_SRC];

  always_comb begin
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqd_seq.sv
module irqd_seq #(
  parameter int unsigned CLK_PER_MCYC  = 4,
  parameter int unsigned DISPATCH_MCYC = 5,
  localparam int unsigned TOTAL   = CLK_PER_MCYC * DISPATCH_MCYC,
  localparam int unsigned CNT_W   = $clog2(TOTAL),
  localparam int unsigned HI_SLOT = 2 * CLK_PER_MCYC,
  localparam int unsigned LO_SLOT = 3 * CLK_PER_MCYC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [15:0] vec,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  output logic        busy,
  output logic        done,
  output logic        stack_we,
  output logic [15:0] stack_addr,
  output logic [7:0]  stack_wdata,
  output logic [15:0] pc_out,
  output logic [15:0] sp_out
);
  import irqd_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      pc_q, sp_q, vec_q;
  logic             hi_wr, lo_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      pc_q  <= '0;
      sp_q  <= '0;
      vec_q <= '0;
    end else if (take) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      pc_q  <= pc_in;
      sp_q  <= sp_in;
      vec_q <= vec;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done  = busy && (cnt_q == CNT_W'(TOTAL - 1));
  assign hi_wr = busy && (cnt_q == CNT_W'(HI_SLOT));
  assign lo_wr = busy && (cnt_q == CNT_W'(LO_SLOT));

  assign stack_we    = hi_wr | lo_wr;
  assign stack_addr  = hi_wr ? stack_slot(sp_q, 1) : stack_slot(sp_q, 2);
  assign stack_wdata = hi_wr ? pc_q[15:8] : pc_q[7:0];
  assign pc_out      = vec_q;
  assign sp_out      = stack_slot(sp_q, 2);
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl #(
  parameter int unsigned N_SRC         = 5,
  parameter int unsigned CLK_PER_MCYC  = 4,
  parameter int unsigned DISPATCH_MCYC = 5,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             ime_set,
  input  logic             ime_clr,
  output logic             ime,
  input  logic             cpu_halted,
  output logic             halt_wake,
  input  logic             insn_boundary,
  input  logic [15:0]      pc_in,
  input  logic [15:0]      sp_in,
  output logic             busy,
  output logic             stack_we,
  output logic [15:0]      stack_addr,
  output logic [7:0]       stack_wdata,
  output logic [15:0]      pc_out,
  output logic [15:0]      sp_out,
  output logic             done
);
  import irqd_pkg::*;

  logic [7:0]       en_q;
  logic [N_SRC-1:0] flag_q, pend, grant, ack;
  logic [IDX_W-1:0] win_idx;
  logic             pend_any, take, flag_wr;
  logic [15:0]      win_vec;

  assign pend      = en_q[N_SRC-1:0] & flag_q;
  assign take      = insn_boundary && ime && pend_any && !busy;
  assign ack       = take ? grant : '0;
  assign halt_wake = cpu_halted && pend_any;
  assign win_vec   = vector_for(int'(win_idx));

  irqd_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .irq_req(irq_req), .ack(ack), .take(take),
    .ime_set(ime_set), .ime_clr(ime_clr),
    .en_q(en_q), .flag_q(flag_q), .flag_wr(flag_wr), .ime_q(ime),
    .rdata(bus_rdata)
  );

  irqd_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend(pend), .grant(grant), .idx(win_idx), .any(pend_any)
  );

  irqd_seq #(.CLK_PER_MCYC(CLK_PER_MCYC), .DISPATCH_MCYC(DISPATCH_MCYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .vec(win_vec),
    .pc_in(pc_in), .sp_in(sp_in),
    .busy(busy), .done(done),
    .stack_we(stack_we), .stack_addr(stack_addr), .stack_wdata(stack_wdata),
    .pc_out(pc_out), .sp_out(sp_out)
  );
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int unsigned N_SRC = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take,
  input logic             busy,
  input logic             done,
  input logic             ime,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] ack,
  input logic [N_SRC-1:0] flag,
  input logic             flag_wr,
  input logic [N_SRC-1:0] irq_req,
  input logic             stack_we,
  input logic             halted,
  input logic             halt_wake
);
  a_r1_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(take));

  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |-> ((((ack - 1'b1) & pend) == '0) && ((ack & pend) == ack)));

  a_r4_ime_drops: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ime);

  a_r5_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  a_r5_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack) && !flag_wr) |=> ((flag & $past(flag & ~ack)) == $past(flag & ~ack)));

  a_r6_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stack_we |-> busy);

  a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  a_r8_wake_any_ime: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && (|pend)) |-> halt_wake);

  a_r10_set_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |=> ((flag & $past(irq_req)) == $past(irq_req)));
endmodule

bind irq_dispatch_ctrl irqd_checker #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .busy(busy), .done(done),
  .ime(ime), .pend(pend), .ack(ack), .flag(flag_q), .flag_wr(flag_wr),
  .irq_req(irq_req), .stack_we(stack_we), .halted(cpu_halted),
  .halt_wake(halt_wake)
);

// File: tb/irq_dispatch_ctrl_tb.sv
`timescale 1ns/100ps
module irq_dispatch_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [4:0]  irq_req = 5'h00;
  logic        ime_set = 1'b0, ime_clr = 1'b0, ime;
  logic        cpu_halted = 1'b0, halt_wake;
  logic        insn_boundary = 1'b0;
  logic [15:0] pc_in = 16'h0000, sp_in = 16'h0000;
  logic        busy, stack_we, done;
  logic [15:0] stack_addr, pc_out, sp_out;
  logic [7:0]  stack_wdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_dispatch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .ime_set(ime_set), .ime_clr(ime_clr), .ime(ime),
    .cpu_halted(cpu_halted), .halt_wake(halt_wake),
    .insn_boundary(insn_boundary), .pc_in(pc_in), .sp_in(sp_in),
    .busy(busy), .stack_we(stack_we), .stack_addr(stack_addr),
    .stack_wdata(stack_wdata), .pc_out(pc_out), .sp_out(sp_out), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model: state as integers, stepped on each rising edge.
  int m_en, m_flag, m_ime, m_busy, m_left, m_vec, m_pc, m_sp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_flag = 0; m_ime = 0; m_busy = 0; m_left = 0;
      m_vec = 0; m_pc = 0; m_sp = 0;
    end else begin
      int p, w, f;
      bit start;
      p = m_en & m_flag & 31;
      w = -1;
      for (int k = 4; k >= 0; k--) if (p[k]) w = k;
      start = insn_boundary && (m_ime != 0) && (p != 0) && (m_busy == 0);
      f = m_flag;
      if (bus_wr && bus_addr == 16'hFF0F) f = bus_wdata & 31;
      else if (start) f = f & ~(1 << w);
      f = f | irq_req;
      if (bus_wr && bus_addr == 16'hFFFF) m_en = bus_wdata;
      m_flag = f;
      if (start || ime_clr) m_ime = 0;
      else if (ime_set) m_ime = 1;
      if (start) begin
        m_busy = 1; m_left = 20; m_vec = 64 + 8 * w;
        m_pc = pc_in; m_sp = sp_in;
      end else if (m_busy != 0) begin
        m_left--;
        if (m_left == 0) m_busy = 0;
      end
    end
  end

  // Compare every output 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    begin
      int el, er, pos;
      pos = 20 - m_left;  // busy cycle index from 0
      er = 0;
      if (bus_addr == 16'hFFFF) er = m_en;
      else if (bus_addr == 16'hFF0F) er = 8'hE0 | m_flag;
      chk("R9 bus_rdata", bus_rdata, er);
      chk("R4 ime", ime, m_ime);
      chk("R8 halt_wake", halt_wake, (cpu_halted && ((m_en & m_flag & 31) != 0)) ? 1 : 0);
      chk("R7 busy", busy, m_busy);
      el = (m_busy != 0 && pos == 19) ? 1 : 0;
      chk("R7 done", done, el);
      if (el != 0) begin
        chk("R3 pc_out", pc_out, m_vec);
        chk("R6 sp_out", sp_out, (m_sp - 2) & 16'hFFFF);
      end
      el = (m_busy != 0 && (pos == 8 || pos == 12)) ? 1 : 0;
      chk("R6 stack_we", stack_we, el);
      if (el != 0 && pos == 8) begin
        chk("R6 hi addr", stack_addr, (m_sp - 1) & 16'hFFFF);
        chk("R6 hi data", stack_wdata, (m_pc >> 8) & 8'hFF);
      end
      if (el != 0 && pos == 12) begin
        chk("R6 lo addr", stack_addr, (m_sp - 2) & 16'hFFFF);
        chk("R6 lo data", stack_wdata, m_pc & 8'hFF);
      end
    end
  end

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 16'h0000;
  endtask

  task automatic rd_check(input string tag, input logic [15:0] a, input int exp);
    @(negedge clk); bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic ime_on();
    @(negedge clk); ime_set = 1'b1;
    @(negedge clk); ime_set = 1'b0;
  endtask

  task automatic boundary(input logic [15:0] pc, input logic [15:0] sp);
    @(negedge clk); pc_in = pc; sp_in = sp; insn_boundary = 1'b1;
    @(negedge clk); insn_boundary = 1'b0;
  endtask

  task automatic wait_done(input string tag, input int exp_vec);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (done) break;
    end
    chk(tag, pc_out, exp_vec);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    rd_check("R9 reset flags", 16'hFF0F, 8'hE0);
    rd_check("R9 reset enable", 16'hFFFF, 8'h00);
    chk("R4 reset ime", ime, 0);

    // Basic dispatch, source 0, push of 0x1234 from SP 0xFFFE
    bus_write(16'hFFFF, 8'h01);
    @(negedge clk); irq_req = 5'h01;
    @(negedge clk); irq_req = 5'h00;
    ime_on();
    boundary(16'h1234, 16'hFFFE);
    chk("R1 busy after take", busy, 1);
    chk("R4 ime dropped", ime, 0);
    wait_done("R3 vector 0", 16'h0040);
    chk("R6 new sp", sp_out, 16'hFFFC);
    rd_check("R5 flag cleared", 16'hFF0F, 8'hE0);

    // R7: busy length
    bus_write(16'hFF0F, 8'h01);
    ime_on();
    boundary(16'h0100, 16'hC000);
    begin
      int n = 0;
      while (busy && n < 40) begin @(posedge clk); #1; n++; end
      chk("R7 busy cycles", n, 20);
    end

    // R2 / R5: priority with bits 0 and 2 pending
    bus_write(16'hFFFF, 8'h1F);
    bus_write(16'hFF0F, 8'h05);
    ime_on();
    boundary(16'hABCD, 16'hD000);
    // R1: boundary and ime while busy restart nothing
    ime_on();
    boundary(16'h5555, 16'hE000);
    wait_done("R2 bit0 first", 16'h0040);
    rd_check("R5 bit2 kept", 16'hFF0F, 8'hE4);
    ime_clr = 1'b0;
    boundary(16'h0200, 16'hD000);
    wait_done("R2 bit2 next", 16'h0050);
    rd_check("R5 all clear", 16'hFF0F, 8'hE0);

    // R3: every vector
    for (int i = 0; i < 5; i++) begin
      bus_write(16'hFF0F, 8'(1 << i));
      ime_on();
      boundary(16'(16'h3000 + i), 16'h8000);
      wait_done("R3 vector", 64 + 8 * i);
    end

    // R1: global enable clear blocks a dispatch
    bus_write(16'hFF0F, 8'h01);
    boundary(16'h0000, 16'h8000);
    chk("R1 no take with ime clear", busy, 0);
    // R8: wake regardless of ime
    @(negedge clk); cpu_halted = 1'b1; #1;
    chk("R8 wake ime clear", halt_wake, 1);
    @(negedge clk); cpu_halted = 1'b0; #1;
    chk("R8 no wake when running", halt_wake, 0);

    // R4: clear wins over set
    @(negedge clk); ime_set = 1'b1; ime_clr = 1'b1;
    @(negedge clk); ime_set = 1'b0; ime_clr = 1'b0;
    chk("R4 clr wins", ime, 0);

    // R9: enable bits 7:5 ignored for pending
    bus_write(16'hFFFF, 8'hE0);
    bus_write(16'hFF0F, 8'hFF);
    rd_check("R9 enable readback", 16'hFFFF, 8'hE0);
    rd_check("R9 flag readback", 16'hFF0F, 8'hFF);
    rd_check("R9 other addr", 16'h1234, 8'h00);
    @(negedge clk); cpu_halted = 1'b1; #1;
    chk("R9 high enable no wake", halt_wake, 0);
    @(negedge clk); cpu_halted = 1'b0;
    ime_on();
    boundary(16'h0000, 16'h8000);
    chk("R9 high enable no take", busy, 0);
    @(negedge clk); ime_clr = 1'b1;
    @(negedge clk); ime_clr = 1'b0;

    // R10: set of another bit during a dispatch clear
    bus_write(16'hFFFF, 8'h01);
    bus_write(16'hFF0F, 8'h01);
    ime_on();
    @(negedge clk); insn_boundary = 1'b1; irq_req = 5'h08;
    @(negedge clk); insn_boundary = 1'b0; irq_req = 5'h00;
    chk("R10 take with set", busy, 1);
    rd_check("R10 other set kept", 16'hFF0F, 8'hE8);
    wait_done("R10 vector", 16'h0040);

    // R10: set of the same bit being cleared
    bus_write(16'hFF0F, 8'h01);
    ime_on();
    @(negedge clk); insn_boundary = 1'b1; irq_req = 5'h01;
    @(negedge clk); insn_boundary = 1'b0; irq_req = 5'h00;
    rd_check("R10 same bit set wins", 16'hFF0F, 8'hE1);
    wait_done("R10 vector", 16'h0040);

    // R10: bus write beats dispatch clear
    bus_write(16'hFFFF, 8'h03);
    bus_write(16'hFF0F, 8'h03);
    ime_on();
    @(negedge clk); insn_boundary = 1'b1;
    bus_addr = 16'hFF0F; bus_wr = 1'b1; bus_wdata = 8'h03;
    @(negedge clk); insn_boundary = 1'b0; bus_wr = 1'b0;
    rd_check("R10 write wins", 16'hFF0F, 8'hE3);
    wait_done("R10 vector", 16'h0040);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule